// File: doc/BRIEF.md
# Set-Reset Compare Waveform Generator

This block turns one 16-bit up-counter into several pulse outputs. Each output channel owns two compare registers. When the counter reaches the first value, the channel's internal state goes active. When it reaches the second value, the state goes inactive. The pulse edges are therefore placed by two independent numbers rather than by toggling. Every compare match also sets a sticky flag bit, which software clears by writing zero to it.

The counter advances only on a single-cycle `tick` strobe. It can run freely through the full 16-bit range. It can instead restart after reaching a programmable limit, which is taken either from a dedicated period register or from compare register 0. In the second case channel 0 loses its waveform.

Per-channel control bits select:
- the idle (default) level,
- an inversion applied after the set/reset state,
- an output-off switch that parks the pin at its default level.

All registers are loaded through a plain address/data/write-enable port and act from the next clock edge.

Top module: `sr_wavegen`

## Requirements
- R1: After reset, `cnt_o` is 0, every `wave_o` bit is 0 and every `flag_o` bit is 0. All registers reset to 0.
- R2: The counter changes only on a clock edge where `tick` is 1, and then only by +1 or to 0. In free-running operation it goes from FFFFh to 0000h, giving a 65536-tick period. Any restart-select value other than 001b or 100b counts as free-running.
- R3: For channel i, on a tick whose new counter value equals C[2i], the channel state goes active. On a tick whose new value equals C[2i+1], the state goes inactive. `wave_o[i]` changes on the same edge that the counter takes that value. With set value m below reset value n, the output is active for n−m ticks of each free-running period.
- R4: If set and reset match on the same tick, the reset match wins and the channel state is inactive.
- R5: A match on compare register j sets `flag_o[j]`. The bit stays set until software clears it.
- R6: A write to address 14 clears each flag bit whose data bit (bit j for flag j) is 0 and leaves bits written 1 unchanged. A match in the same cycle keeps its flag set.
- R7: With restart-select 100b and period register value p, the counter runs 0..p+1 and then returns to 0, a period of p+2 ticks. With p = FFFFh it wraps naturally after 65536 ticks. If the counter is already past p+1, it runs on to the natural wrap.
- R8: With restart-select 001b, compare register 0 supplies the limit instead, with the same p+2 period. Channel 0's output is then held at its default level.
- R9: Control register of channel i is at address 10+i and has three bits:
  - bit0: default level
  - bit1: invert
  - bit2: output off

  `wave_o[i]` equals the default level when output-off is 1, and the channel state XOR invert otherwise.
- R10: A write to a channel's control register loads the channel state with the new default-level bit. This load takes priority over a match in the same cycle.
- R11: Address map:
  - 0..7: compare registers C0..C7
  - 8: period
  - 9: restart-select in bits 2:0, where bit0 selects compare-0 restart and bit2 selects period restart
  - 15: unused, and writes there are ignored

  A written value is used by the compare and restart logic from the next tick.
- R12: `rst_n` resets asynchronously, but its release takes effect two clock edges later. The first counter increment happens on the third edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable strobe, one cycle per timer step |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| cnt_o | output | 16 | Current counter value |
| wave_o | output | 4 | Channel outputs |
| flag_o | output | 8 | Sticky match flags, one per compare register |

## Verification
A wrong set/reset state in a channel shows on `wave_o` at the very edge where the counter takes a compare value, unless that channel is switched off. A wrong restart decision shows on `cnt_o` one tick later, as a value past the expected limit or an early zero. A lost or wrongly cleared flag is visible on `flag_o` in the cycle after the match or the clear write. A cycle-accurate bench model therefore catches each of these within one clock.

// File: rtl/srwg_pkg.sv
package srwg_pkg;

  typedef enum logic [1:0] {
    RS_FREE   = 2'd0,
    RS_CMP0   = 2'd1,
    RS_PERIOD = 2'd2
  } restart_e;

  // bit2 off, bit1 inv, bit0 dflt
  typedef struct packed {
    logic off;
    logic inv;
    logic dflt;
  } chan_ctl_t;

  function automatic restart_e decode_restart(input logic [2:0] sel);
    case (sel)
      3'b001:  return RS_CMP0;
      3'b100:  return RS_PERIOD;
      default: return RS_FREE;
    endcase
  endfunction

endpackage

// File: rtl/srwg_rst_sync.sv
module srwg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/srwg_regs.sv
module srwg_regs
  import srwg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [CNT_W-1:0]             wr_data,
  input  logic [2*NUM_CH-1:0]          cmp_hit,
  output logic [2*NUM_CH-1:0][CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0]             period_o,
  output restart_e                     mode_o,
  output chan_ctl_t [NUM_CH-1:0]       ctl_o,
  output logic [NUM_CH-1:0]            ctl_wr_o,
  output logic                         flag_wr_o,
  output logic [2*NUM_CH-1:0]          flag_o
);
  localparam int NCMP      = 2 * NUM_CH;
  localparam int PER_ADDR  = NCMP;
  localparam int MODE_ADDR = PER_ADDR + 1;
  localparam int CTL_BASE  = MODE_ADDR + 1;
  localparam int FLAG_ADDR = CTL_BASE + NUM_CH;

  logic [NCMP-1:0][CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0]           per_q, per_d;
  logic [2:0]                 sel_q, sel_d;
  chan_ctl_t [NUM_CH-1:0]     ctl_q, ctl_d;
  logic [NCMP-1:0]            flag_q, flag_d;

  // Compare registers
  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    always_comb begin
      cmp_d[g] = cmp_q[g];
      if (wr_en && (wr_addr == ADDR_W'(g))) cmp_d[g] = wr_data;
    end
  end

  // Channel controls
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ctl
    always_comb begin
      ctl_wr_o[c] = wr_en && (wr_addr == ADDR_W'(CTL_BASE + c));
      ctl_d[c]    = ctl_wr_o[c] ? chan_ctl_t'(wr_data[2:0]) : ctl_q[c];
    end
  end

  always_comb begin
    per_d = per_q;
    if (wr_en && (wr_addr == ADDR_W'(PER_ADDR))) per_d = wr_data;
    sel_d = sel_q;
    if (wr_en && (wr_addr == ADDR_W'(MODE_ADDR))) sel_d = wr_data[2:0];
    flag_wr_o = wr_en && (wr_addr == ADDR_W'(FLAG_ADDR));
    flag_d    = flag_q;
    if (flag_wr_o) flag_d = flag_q & wr_data[NCMP-1:0];
    flag_d    = flag_d | cmp_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      per_q  <= '0;
      sel_q  <= '0;
      ctl_q  <= '0;
      flag_q <= '0;
    end else begin
      cmp_q  <= cmp_d;
      per_q  <= per_d;
      sel_q  <= sel_d;
      ctl_q  <= ctl_d;
      flag_q <= flag_d;
    end
  end

  assign cmp_o    = cmp_q;
  assign period_o = per_q;
  assign mode_o   = decode_restart(sel_q);
  assign ctl_o    = ctl_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/srwg_timebase.sv
module srwg_timebase
  import srwg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  restart_e         mode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp0,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   restart_at;
  logic             restart;

  always_comb begin
    limit      = (mode == RS_CMP0) ? cmp0 : period;
    restart_at = {1'b0, limit} + 1'b1;
    restart    = (mode != RS_FREE) && ({1'b0, cnt_q} == restart_at);
    cnt_nxt_o  = restart ? '0 : cnt_q + 1'b1;
    cnt_d      = tick ? cnt_nxt_o : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/srwg_channel.sv
module srwg_channel
  import srwg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp_set,
  input  logic [CNT_W-1:0] cmp_clr,
  input  chan_ctl_t        ctl,
  input  logic             ld_en,
  input  logic             ld_val,
  input  logic             force_dflt,
  output logic             set_hit,
  output logic             clr_hit,
  output logic             core_o,
  output logic             wave_o
);
  logic core_q, core_d;

  always_comb begin
    set_hit = tick && (cnt_nxt == cmp_set);
    clr_hit = tick && (cnt_nxt == cmp_clr);
    if (ld_en)        core_d = ld_val;
    else if (clr_hit) core_d = 1'b0;
    else if (set_hit) core_d = 1'b1;
    else              core_d = core_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_q <= 1'b0;
    else        core_q <= core_d;
  end

  assign core_o = core_q;
  assign wave_o = (ctl.off || force_dflt) ? ctl.dflt : (core_q ^ ctl.inv);
endmodule

// File: rtl/sr_wavegen.sv
module sr_wavegen
  import srwg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [CNT_W-1:0]      wr_data,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [NUM_CH-1:0]     wave_o,
  output logic [2*NUM_CH-1:0]   flag_o
);
  localparam int NCMP = 2 * NUM_CH;

  logic                        rst_n_sync;
  logic [NCMP-1:0][CNT_W-1:0]  cmp;
  logic [CNT_W-1:0]            period;
  restart_e                    mode;
  chan_ctl_t [NUM_CH-1:0]      ctl;
  logic [NUM_CH-1:0]           ctl_wr;
  logic                        flag_wr;
  logic [NCMP-1:0]             cmp_hit;
  logic [NUM_CH-1:0]           set_hit, clr_hit, core, force_dflt;
  logic [CNT_W-1:0]            cnt_nxt;

  srwg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  srwg_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmp_hit(cmp_hit), .cmp_o(cmp), .period_o(period),
    .mode_o(mode), .ctl_o(ctl), .ctl_wr_o(ctl_wr), .flag_wr_o(flag_wr),
    .flag_o(flag_o)
  );

  srwg_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n_sync), .tick(tick), .mode(mode),
    .period(period), .cmp0(cmp[0]), .cnt_o(cnt_o), .cnt_nxt_o(cnt_nxt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i == 0) begin : g_shared
      assign force_dflt[i] = (mode == RS_CMP0);
    end else begin : g_plain
      assign force_dflt[i] = 1'b0;
    end

    srwg_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n_sync), .tick(tick), .cnt_nxt(cnt_nxt),
      .cmp_set(cmp[2*i]), .cmp_clr(cmp[2*i+1]), .ctl(ctl[i]),
      .ld_en(ctl_wr[i]), .ld_val(wr_data[0]), .force_dflt(force_dflt[i]),
      .set_hit(set_hit[i]), .clr_hit(clr_hit[i]), .core_o(core[i]),
      .wave_o(wave_o[i])
    );

    assign cmp_hit[2*i]   = set_hit[i];
    assign cmp_hit[2*i+1] = clr_hit[i];
  end
endmodule

// File: rtl/srwg_chk.sv
module srwg_chk
  import srwg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic [CNT_W-1:0]      cnt,
  input logic [NUM_CH-1:0]     core,
  input logic [NUM_CH-1:0]     set_hit,
  input logic [NUM_CH-1:0]     clr_hit,
  input logic [NUM_CH-1:0]     ctl_wr,
  input logic                  flag_wr,
  input logic [2*NUM_CH-1:0]   flags,
  input logic [NUM_CH-1:0]     wave,
  input chan_ctl_t [NUM_CH-1:0] ctl
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[i] && !ctl_wr[i]) |=> !core[i]);

    // R3
    set_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hit[i] && !clr_hit[i] && !ctl_wr[i]) |=> core[i]);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[i] |=> flags[2*i]);

    // R9
    off_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl[i].off |-> (wave[i] == ctl[i].dflt));
  end

  for (genvar j = 0; j < 2*NUM_CH; j++) begin : g_flag
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[j] && !flag_wr) |=> flags[j]);
  end
endmodule

bind sr_wavegen srwg_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .tick(tick), .cnt(cnt_o), .core(core),
  .set_hit(set_hit), .clr_hit(clr_hit), .ctl_wr(ctl_wr), .flag_wr(flag_wr),
  .flags(flag_o), .wave(wave_o), .ctl(ctl)
);

// File: tb/tb_sr_wavegen.sv
module tb_sr_wavegen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] cnt_o;
  logic [3:0]  wave_o;
  logic [7:0]  flag_o;

  int n_vec = 0;
  int n_bad = 0;
  bit chk_on = 0;
  bit done = 0;

  sr_wavegen dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_o(cnt_o), .wave_o(wave_o), .flag_o(flag_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference state built from the requirements
  logic [15:0] m_cmp [8];
  logic [15:0] m_per;
  logic [2:0]  m_sel;
  logic [2:0]  m_ctl [4];
  logic [3:0]  m_core;
  logic [7:0]  m_flag;
  logic [15:0] m_cnt;

  function automatic logic [15:0] next_count();
    logic [16:0] lim;
    bit          rs;
    rs  = (m_sel == 3'b001) || (m_sel == 3'b100);
    lim = (m_sel == 3'b001) ? {1'b0, m_cmp[0]} : {1'b0, m_per};
    if (rs && ({1'b0, m_cnt} == lim + 17'd1)) return 16'd0;
    return m_cnt + 16'd1;
  endfunction

  function automatic logic exp_wave(int i);
    bit forced;
    forced = m_ctl[i][2] || (i == 0 && m_sel == 3'b001);
    return forced ? m_ctl[i][0] : (m_core[i] ^ m_ctl[i][1]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) m_cmp[k] = '0;
      for (int k = 0; k < 4; k++) m_ctl[k] = '0;
      m_per = '0; m_sel = '0; m_core = '0; m_flag = '0; m_cnt = '0;
    end else begin
      logic [15:0] nxt;
      logic [7:0]  hit;
      nxt = next_count();
      for (int k = 0; k < 8; k++) hit[k] = tick && (nxt == m_cmp[k]);
      for (int i = 0; i < 4; i++) begin
        if (wr_en && wr_addr == 4'(10 + i)) m_core[i] = wr_data[0];
        else if (hit[2*i+1])                m_core[i] = 1'b0;
        else if (hit[2*i])                  m_core[i] = 1'b1;
      end
      if (wr_en && wr_addr == 4'd14) m_flag = m_flag & wr_data[7:0];
      m_flag = m_flag | hit;
      if (wr_en) begin
        if (wr_addr < 4'd8)                          m_cmp[wr_addr[2:0]] = wr_data;
        else if (wr_addr == 4'd8)                    m_per = wr_data;
        else if (wr_addr == 4'd9)                    m_sel = wr_data[2:0];
        else if (wr_addr >= 4'd10 && wr_addr < 4'd14) m_ctl[wr_addr - 4'd10] = wr_data[2:0];
      end
      if (tick) m_cnt = nxt;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      logic [3:0] ew;
      for (int i = 0; i < 4; i++) ew[i] = exp_wave(i);
      check("R2 counter", int'(cnt_o), int'(m_cnt));
      check("R3 waves", int'(wave_o), int'(ew));
      check("R5 flags", int'(flag_o), int'(m_flag));
    end
  end

  task automatic cyc(bit t);
    tick = t; wr_en = 0;
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    tick = 0; wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic apply_reset();
    rst_n = 0; tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    int hi;
    int mx;
    int bad;
    void'($urandom(32'd4711));
    apply_reset();

    // R12: release takes two edges; first increment on third edge
    tick = 1;
    @(negedge clk); check("R12 edge1", int'(cnt_o), 0);
    @(negedge clk); check("R12 edge2", int'(cnt_o), 0);
    @(negedge clk); check("R12 edge3", int'(cnt_o), 1);

    apply_reset();
    repeat (3) cyc(0);
    // R1: reset state
    check("R1 cnt", int'(cnt_o), 0);
    check("R1 wave", int'(wave_o), 0);
    check("R1 flag", int'(flag_o), 0);
    chk_on = 1;

    // R3/R2: free-running, channel 1 set at 10, reset at 30
    wr(4'd2, 16'd10);
    wr(4'd3, 16'd30);
    hi = 0;
    for (int k = 0; k < 65536; k++) begin
      cyc(1);
      if (wave_o[1]) hi++;
    end
    check("R3 active ticks", hi, 30 - 10);
    check("R2 wrap", int'(cnt_o), 0);
    check("R5 flag2/3", int'(flag_o[3:2]), 3);

    // R6: write-0 clears flag 3 only
    wr(4'd14, 16'h00F7);
    check("R6 clear", int'(flag_o[3:2]), 1);

    // R7: period restart, p = 99 -> 101 ticks
    wr(4'd8, 16'd99);
    wr(4'd9, 16'h0004);
    hi = 0; mx = 0;
    for (int k = 0; k < 101; k++) begin
      cyc(1);
      if (wave_o[1]) hi++;
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
    end
    check("R7 period end", int'(cnt_o), 0);
    check("R7 max count", mx, 100);
    check("R7 active ticks", hi, 20);

    // R8: compare-0 restart, C0 = 49, channel 0 parked at default 1
    wr(4'd0, 16'd49);
    wr(4'd1, 16'd20);
    wr(4'd9, 16'h0001);
    wr(4'd10, 16'h0001);
    bad = 0;
    for (int k = 0; k < 51; k++) begin
      cyc(1);
      if (wave_o[0] != 1'b1) bad++;
    end
    check("R8 period end", int'(cnt_o), 0);
    check("R8 ch0 parked", bad, 0);

    // R9/R10: inversion, output off, default-level load
    wr(4'd11, 16'h0002);
    check("R9 invert idle", int'(wave_o[1]), 1);
    wr(4'd11, 16'h0004);
    bad = 0;
    for (int k = 0; k < 51; k++) begin
      cyc(1);
      if (wave_o[1] != 1'b0) bad++;
    end
    check("R9 off level", bad, 0);
    wr(4'd11, 16'h0001);
    check("R10 load dflt", int'(wave_o[1]), 1);

    // R4: equal set and reset on channel 2
    wr(4'd4, 16'd20);
    wr(4'd5, 16'd20);
    wr(4'd12, 16'h0000);
    wr(4'd8, 16'd40);
    wr(4'd9, 16'h0004);
    wr(4'd14, 16'h0000);
    hi = 0;
    for (int k = 0; k < 42; k++) begin
      cyc(1);
      if (wave_o[2]) hi++;
    end
    check("R4 reset wins", hi, 0);
    check("R4 both flags", int'(flag_o[5:4]), 3);

    // R11/R2: illegal restart-select runs free past the limit
    wr(4'd8, 16'd5);
    wr(4'd9, 16'h0005);
    mx = int'(cnt_o);
    repeat (10) cyc(1);
    check("R11 free on bad select", int'(cnt_o), mx + 10);
    wr(4'd15, 16'hFFFF);
    repeat (2) cyc(0);
    check("R11 ignored addr", int'(cnt_o), mx + 10);

    // Random phase against the model (R2, R3, R5, R6, R9, R10, R11)
    for (int k = 0; k < 4000; k++) begin
      tick    = ($urandom % 2) == 0;
      wr_en   = ($urandom % 5) == 0;
      wr_addr = 4'($urandom % 16);
      wr_data = (wr_addr < 4'd9) ? 16'($urandom % 64) : 16'($urandom);
      @(negedge clk);
    end
    wr_en = 0; tick = 0;
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cycles;
    cycles = 0;
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected done", cycles);
    end
    chk_on = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule